// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers 32-bit CPU addresses toward devices on an on-chip fabric. It keeps a bank of twenty programmable windows. Each window has an enable, a base, a size given as a (size − 1) mask with 64 KB granularity, a 4-bit target code and an 8-bit attribute code. Every cycle the incoming address is compared against all windows at once. The registered result gives a hit flag, a miss flag, the target and attribute of the winning window, and the outgoing address.

The lowest eight windows can also translate addresses. On a hit in one of them, the address bits covered by the base are replaced by a programmed remap value. The upper twelve windows pass the address through unchanged.

Software programs the windows through a 32-bit word register port with byte offsets. The layout is not uniform. The translating windows take four words each. A 16-byte reserved hole follows them. The plain windows then take two words each. Reset leaves every window disabled.

Top module: `addr_win_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it, every window register is cleared: `out_hit`=0, `out_miss`=1 and `cfg_rdata`=0. All windows stay disabled until they are written.
- R2: Window w < 8 has its control, base, remap-low and remap-high words at byte offsets 16w, 16w+4, 16w+8 and 16w+12. Window w ≥ 8 has only control and base, at 0x90+8(w−8) and 0x94+8(w−8).
- R3: Control word fields:
  - bit 0 is the enable.
  - bits 7:4 are the target code.
  - bits 15:8 are the attribute code.
  - bits 31:16 are the size mask, upper half of (size − 1).
  - bits 3:1 always read as zero.
- R4: Base word fields: bits 31:16 hold address bits 31:16, and bits 3:0 hold address bits 35:32. All other bits read as zero.
- R5: Remap-low keeps only bits 31:16; its other bits read as zero. Remap-high always reads zero, and writes to it are ignored.
- R6: Offsets 0x80–0x8F, and every offset at or above 0xF0, read as zero. Writes to them change no window register.
- R7: A window matches when all three conditions hold:
  - its enable bit is 1;
  - its base bits 35:32 are zero;
  - (addr[31:16] & ~mask) equals (base[31:16] & ~mask).
  A disabled window never matches.
- R8: On a hit in a window below 8, bits 31:16 of the output address are (remap[31:16] & ~mask) | (addr[31:16] & mask).
- R9: On a hit in a window at 8 or above, the address passes through unchanged. Bits 15:0 of the output address always equal the input address bits.
- R10: When several enabled windows match, the lowest-numbered one supplies the target, attribute and translation.
- R11: On a miss, `out_miss`=1, `out_hit`=0, the target and attribute are 0, and the output address equals the input address.
- R12: Each decode result appears one cycle after its address. A register write takes effect at the clock edge that captures it. A lookup captured at that same edge still sees the old configuration. Register reads return data one cycle after the offset is presented.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous offset |
| in_addr | input | 32 | CPU address to decode |
| out_hit | output | 1 | Registered: an enabled window matched |
| out_miss | output | 1 | Registered: no window matched |
| out_target | output | 4 | Target code of the winning window, 0 on miss |
| out_attr | output | 8 | Attribute code of the winning window, 0 on miss |
| out_addr | output | 32 | Translated or passed-through address |

## Verification
A register write and a lookup can land on the same clock edge, and both can involve the same window. The bench provokes this by enabling a translating window in the very cycle an address inside it is presented. The result for that cycle must be a miss, and the next cycle must give the translated hit. The same check is then repeated with the window being disabled, where the hit must survive exactly one more cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Window field widths, fixed by the register format
  localparam int SZ_W   = 16;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;
  localparam int HI_W   = 4;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [SZ_W-1:0]   mask;
    logic [SZ_W-1:0]   base;
    logic [HI_W-1:0]   base_hi;
    logic [SZ_W-1:0]   remap;
  } win_cfg_t;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN  = 20,
  parameter int NUM_XLAT = 8,
  parameter int CFG_AW   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  output win_cfg_t [NUM_WIN-1:0]     cfg_o
);

  localparam int WIN_W      = $clog2(NUM_WIN);
  localparam int XLAT_END   = NUM_XLAT * 16;
  localparam int PLAIN_BASE = XLAT_END + 16;
  localparam int PLAIN_END  = PLAIN_BASE + (NUM_WIN - NUM_XLAT) * 8;

  int               a;
  logic             dec_valid;
  logic [WIN_W-1:0] dec_win;
  logic [1:0]       dec_sel;   // 0 ctrl, 1 base, 2 remap low, 3 remap high

  // Offset decode: translating block, reserved hole, plain block
  always_comb begin
    a         = int'(cfg_addr);
    dec_valid = 1'b0;
    dec_win   = '0;
    dec_sel   = 2'd0;
    if (a < XLAT_END) begin
      dec_valid = 1'b1;
      dec_win   = WIN_W'(a / 16);
      dec_sel   = cfg_addr[3:2];
    end else if (a >= PLAIN_BASE && a < PLAIN_END) begin
      dec_valid = 1'b1;
      dec_win   = WIN_W'(NUM_XLAT + (a - PLAIN_BASE) / 8);
      dec_sel   = {1'b0, cfg_addr[2]};
    end
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      logic hit_w;
      assign hit_w = cfg_we && dec_valid && (int'(dec_win) == w);

      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_o[w].en      <= 1'b0;
          cfg_o[w].tgt     <= '0;
          cfg_o[w].attr    <= '0;
          cfg_o[w].mask    <= '0;
          cfg_o[w].base    <= '0;
          cfg_o[w].base_hi <= '0;
        end else if (hit_w && dec_sel == 2'd0) begin
          cfg_o[w].en   <= cfg_wdata[0];
          cfg_o[w].tgt  <= cfg_wdata[7:4];
          cfg_o[w].attr <= cfg_wdata[15:8];
          cfg_o[w].mask <= cfg_wdata[31:16];
        end else if (hit_w && dec_sel == 2'd1) begin
          cfg_o[w].base    <= cfg_wdata[31:16];
          cfg_o[w].base_hi <= cfg_wdata[3:0];
        end
      end

      if (w < NUM_XLAT) begin : g_xlat
        always_ff @(posedge clk) begin
          if (rst)
            cfg_o[w].remap <= '0;
          else if (hit_w && dec_sel == 2'd2)
            cfg_o[w].remap <= cfg_wdata[31:16];
        end
      end else begin : g_plain
        assign cfg_o[w].remap = '0;
      end
    end
  endgenerate

  // Readback, one cycle latency
  logic [31:0] rd_word;
  win_cfg_t    rd_cfg;

  always_comb begin
    rd_word = '0;
    rd_cfg  = cfg_o[dec_win];
    if (dec_valid) begin
      unique case (dec_sel)
        2'd0:    rd_word = {rd_cfg.mask, rd_cfg.attr, rd_cfg.tgt, 3'b000, rd_cfg.en};
        2'd1:    rd_word = {rd_cfg.base, 12'h000, rd_cfg.base_hi};
        2'd2:    rd_word = {rd_cfg.remap, 16'h0000};
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_word;
  end

endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg_i,
  input  logic [SZ_W-1:0]        addr_hi,
  output logic [NUM_WIN-1:0]     match_o
);

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_cmp
      assign match_o[w] = cfg_i[w].en
                       && (cfg_i[w].base_hi == '0)
                       && (((addr_hi ^ cfg_i[w].base) & ~cfg_i[w].mask) == '0);
    end
  endgenerate

endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
#(
  parameter int NUM_WIN  = 20,
  parameter int NUM_XLAT = 8
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg_i,
  input  logic [NUM_WIN-1:0]     match_i,
  input  logic [31:0]            in_addr,
  output logic                   hit_o,
  output logic [TGT_W-1:0]       tgt_o,
  output logic [ATTR_W-1:0]      attr_o,
  output logic [31:0]            addr_o
);

  localparam int WIN_W = $clog2(NUM_WIN);

  logic [WIN_W-1:0] sel_idx;
  win_cfg_t         sel_cfg;

  // Lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel_idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_i[w]) sel_idx = WIN_W'(w);
    end
  end

  assign sel_cfg = cfg_i[sel_idx];
  assign hit_o   = |match_i;

  always_comb begin
    tgt_o  = '0;
    attr_o = '0;
    addr_o = in_addr;
    if (hit_o) begin
      tgt_o  = sel_cfg.tgt;
      attr_o = sel_cfg.attr;
      if (int'(sel_idx) < NUM_XLAT)
        addr_o[31:16] = (sel_cfg.remap & ~sel_cfg.mask) | (in_addr[31:16] & sel_cfg.mask);
    end
  end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN  = 20,
  parameter int NUM_XLAT = 8,
  parameter int CFG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [31:0]       in_addr,
  output logic              out_hit,
  output logic              out_miss,
  output logic [3:0]        out_target,
  output logic [7:0]        out_attr,
  output logic [31:0]       out_addr
);

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     match;
  logic                   hit_c;
  logic [TGT_W-1:0]       tgt_c;
  logic [ATTR_W-1:0]      attr_c;
  logic [31:0]            addr_c;

  awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_o     (cfg)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .cfg_i   (cfg),
    .addr_hi (in_addr[31:16]),
    .match_o (match)
  );

  awd_select #(.NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT)) u_sel (
    .cfg_i   (cfg),
    .match_i (match),
    .in_addr (in_addr),
    .hit_o   (hit_c),
    .tgt_o   (tgt_c),
    .attr_o  (attr_c),
    .addr_o  (addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hit    <= 1'b0;
      out_miss   <= 1'b1;
      out_target <= '0;
      out_attr   <= '0;
      out_addr   <= '0;
    end else begin
      out_hit    <= hit_c;
      out_miss   <= ~hit_c;
      out_target <= tgt_c;
      out_attr   <= attr_c;
      out_addr   <= addr_c;
    end
  end

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN  = 20,
  parameter int NUM_XLAT = 8,
  parameter int CFG_AW   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic [31:0]       in_addr,
  input logic              out_hit,
  input logic              out_miss,
  input logic [3:0]        out_target,
  input logic [7:0]        out_attr,
  input logic [31:0]       out_addr
);

  localparam int XLAT_END   = NUM_XLAT * 16;
  localparam int PLAIN_BASE = XLAT_END + 16;
  localparam int PLAIN_END  = PLAIN_BASE + (NUM_WIN - NUM_XLAT) * 8;

  logic unmapped;
  assign unmapped = (int'(cfg_addr) >= XLAT_END && int'(cfg_addr) < PLAIN_BASE)
                 || (int'(cfg_addr) >= PLAIN_END);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_hit && out_miss && cfg_rdata == 32'h0));

  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(unmapped)) |-> cfg_rdata == 32'h0);

  assert_low_pass_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> out_addr[15:0] == $past(in_addr[15:0]));

  assert_miss_codes_R11: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_target == 4'h0 && out_attr == 8'h00));

  assert_miss_pass_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && out_miss) |-> out_addr == $past(in_addr));

endmodule

bind addr_win_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .NUM_XLAT(NUM_XLAT), .CFG_AW(CFG_AW)
) u_awd_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .in_addr    (in_addr),
  .out_hit    (out_hit),
  .out_miss   (out_miss),
  .out_target (out_target),
  .out_attr   (out_attr),
  .out_addr   (out_addr)
);

// File: tb/tb_addr_win_decoder.sv
`timescale 1ns/1ps
module tb_addr_win_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] in_addr = '0;
  logic        out_hit, out_miss;
  logic [3:0]  out_target;
  logic [7:0]  out_attr;
  logic [31:0] out_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_win_decoder dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_addr(in_addr),
    .out_hit(out_hit), .out_miss(out_miss), .out_target(out_target),
    .out_attr(out_attr), .out_addr(out_addr)
  );

  // Stimulus table: address, {hit, target, attr}, expected output address
  localparam int NV = 10;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h1000_1234, 32'h100F_0042, 32'h1010_0000, 32'h20AB_CDEF, 32'h3000_0010,
    32'h4000_FFFF, 32'h4001_0000, 32'h5001_ABCD, 32'h5000_0001, 32'hFFFF_FFFF};
  localparam logic [12:0] V_RES [NV] = '{
    13'h1111, 13'h1111, 13'h0000, 13'h1999, 13'h0000,
    13'h1FFF, 13'h0000, 13'h1777, 13'h1777, 13'h0000};
  localparam logic [31:0] V_OUT [NV] = '{
    32'h8000_1234, 32'h800F_0042, 32'h1010_0000, 32'h20AB_CDEF, 32'h3000_0010,
    32'h4000_FFFF, 32'h4001_0000, 32'h6001_ABCD, 32'h6000_0001, 32'hFFFF_FFFF};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] data);
    cfg_addr = off;
    @(posedge clk); @(negedge clk);
    data = cfg_rdata;
  endtask

  task automatic decode(input logic [31:0] a);
    in_addr = a;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] res_word();
    return {19'h0, out_hit, out_target, out_attr};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 miss after reset", {31'h0, out_miss}, 32'h1);
    check("R1 hit after reset", {31'h0, out_hit}, 32'h0);
    rd(8'h00, r); check("R1 w0 ctrl cleared", r, 32'h0);
    rd(8'hE8, r); check("R1 w19 ctrl cleared", r, 32'h0);
    decode(32'h0000_0000);
    check("R1 no window enabled", res_word(), 32'h0);

    // Configuration
    wr(8'h04, 32'h1000_0000); wr(8'h08, 32'h8000_0000); wr(8'h00, 32'h000F_1111); // w0
    wr(8'h14, 32'h1000_0000); wr(8'h18, 32'h9000_0000); wr(8'h10, 32'h0000_2221); // w1
    wr(8'h54, 32'h2000_0000); wr(8'h50, 32'h0000_5550);                         // w5 off
    wr(8'h74, 32'h5000_0000); wr(8'h78, 32'h6000_1234); wr(8'h70, 32'h0001_7771); // w7
    wr(8'h9C, 32'h2000_0000); wr(8'h98, 32'h00FF_9991);                         // w9
    wr(8'hB4, 32'h3000_0001); wr(8'hB0, 32'h0000_CCC1);                         // w12
    wr(8'hEC, 32'h4000_0000); wr(8'hE8, 32'h0000_FFF1);                         // w19

    // Table walk: R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      decode(V_ADDR[i]);
      check($sformatf("R7/R10 vec%0d result", i), res_word(), {19'h0, V_RES[i]});
      check($sformatf("R8/R9/R11 vec%0d address", i), out_addr, V_OUT[i]);
      check($sformatf("R11 vec%0d miss flag", i), {31'h0, out_miss}, {31'h0, ~V_RES[i][12]});
    end

    // R2 R3 R4 R5 readback and layout
    rd(8'h00, r); check("R2 R3 w0 ctrl", r, 32'h000F_1111);
    rd(8'h98, r); check("R2 w9 ctrl", r, 32'h00FF_9991);
    rd(8'hEC, r); check("R2 R4 w19 base", r, 32'h4000_0000);
    rd(8'hB4, r); check("R4 w12 base high bits", r, 32'h3000_0001);
    wr(8'hC8, 32'hFFFF_FFFF); rd(8'hC8, r); check("R3 reserved ctrl bits", r, 32'hFFFF_FFF1);
    wr(8'hCC, 32'hFFFF_FFFF); rd(8'hCC, r); check("R4 reserved base bits", r, 32'hFFFF_000F);
    decode(32'h7777_0000); check("R7 high base bits block match", res_word(), 32'h0);
    wr(8'hC8, 32'h0); wr(8'hCC, 32'h0);
    rd(8'h78, r); check("R5 remap low truncated", r, 32'h6000_0000);
    wr(8'h7C, 32'hFFFF_FFFF); rd(8'h7C, r); check("R5 remap high reads zero", r, 32'h0);
    wr(8'hA0, 32'h0000_AAA0); rd(8'hA0, r); check("R2 w10 ctrl", r, 32'h0000_AAA0);
    rd(8'h9C, r); check("R2 w9 base intact", r, 32'h2000_0000);

    // R6 reserved hole and beyond the end
    wr(8'h80, 32'hFFFF_FFFF); wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h80, r); check("R6 gap read", r, 32'h0);
    rd(8'h84, r); check("R6 gap read 2", r, 32'h0);
    rd(8'h90, r); check("R6 w8 ctrl untouched", r, 32'h0);
    wr(8'hF0, 32'hFFFF_FFFF); rd(8'hF0, r); check("R6 beyond end read", r, 32'h0);
    rd(8'h00, r); check("R6 w0 ctrl untouched", r, 32'h000F_1111);
    rd(8'h70, r); check("R6 w7 ctrl untouched", r, 32'h0001_7771);

    // R12 write and lookup on the same edge
    wr(8'h34, 32'h7000_0000); wr(8'h38, 32'h7100_0000);
    cfg_we = 1'b1; cfg_addr = 8'h30; cfg_wdata = 32'h0000_3331;
    in_addr = 32'h7000_0055;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    check("R12 same-edge enable sees old", res_word(), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R12 enabled next cycle", res_word(), 32'h1333);
    check("R12 R8 translated", out_addr, 32'h7100_0055);
    cfg_we = 1'b1; cfg_addr = 8'h30; cfg_wdata = 32'h0;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    check("R12 same-edge disable sees old", res_word(), 32'h1333);
    @(posedge clk); @(negedge clk);
    check("R12 R7 disabled next cycle", res_word(), 32'h0);

    // R1 reset in the middle of operation
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    rd(8'h00, r); check("R1 mid-run reset clears w0", r, 32'h0);
    decode(32'h1000_1234);
    check("R1 mid-run reset disables", res_word(), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule